// File: doc/BRIEF.md
# State Transition Coverage Monitor

This block watches the state code of a small card-game controller and records, in hardware, which of that controller's legal state transitions have been seen. On every clock edge where a sample enable is high, it pairs the state it last sampled with the state it sees now. That pair falls into one of three classes. A pair from the fixed legal list is a coverage bin hit. A pair whose two states are equal counts as no transition. Every other pair is an illegal move.

Each legal bin has a hit flag and a saturating hit counter, and any bin counter can be read through a select input. An illegal pair raises an error pulse and bumps a saturating illegal-event counter. The number of covered bins and a full-coverage flag are always visible. An end-of-test strobe latches a coverage percentage for the controlling environment to read.

State codes are the positions in this list:
- 0 START
- 1 ASK (a card is requested)
- 2 TAKE (a card is received)
- 3 LOW_CHK (the draw-limit test)
- 4 HIGH_CHK (the over-limit test)
- 5 OVER (bust)
- 6 STAND (hold)
- 7 ADJUST (ten is subtracted)

Top module: `trans_cov_mon`

## Requirements
- R1: After reset, the following are all zero: the hit map, every bin counter, the illegal counter, `illegal_o`, `pct_o` and `report_vld_o`. The previous-state valid flag is also cleared.
- R2: The first sampled edge after reset only loads the previous state. No bin is hit and no error is raised. Pairs are formed from the next sampled edge onward.
- R3: A legal pair sets its hit-map bit and adds one to its bin counter at the sampling edge. The bin indices are:

  | Bin | Previous state | Current state |
  |-----|----------------|---------------|
  | 0 | 0 | 1 |
  | 1 | 1 | 2 |
  | 2 | 2 | 3 |
  | 3 | 3 | 4 |
  | 4 | 3 | 1 |
  | 5 | 4 | 5 |
  | 6 | 4 | 6 |
  | 7 | 4 | 7 |
  | 8 | 7 | 3 |

  A hit-map bit never clears until reset.
- R4: Bin counters (8 bit) and the illegal counter (8 bit) stop at 255 and do not wrap.
- R5: A sampled pair with equal previous and current states changes no bin and raises no error.
- R6: A sampled pair of unequal states that is not in the R3 list drives `illegal_o` high for exactly the following cycle and adds one to `illegal_cnt_o`.
- R7: With `sample_i` low, neither the previous state nor any coverage state changes, and `illegal_o` stays low.
- R8: `covered_o` equals the number of set hit-map bits. `full_o` is high exactly when all nine bins are set.
- R9: `eot_i` at an edge loads `pct_o` with floor(covered × 100 / 9) and sets `report_vld_o`. The covered count used is the one from before any bin that the same edge sets.
- R10: `rd_cnt_o` shows the counter of bin `rd_sel_i` combinationally. It reads zero for selects 9 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| state_i | input | 3 | Observed state code |
| sample_i | input | 1 | Sample enable |
| eot_i | input | 1 | End-of-test strobe |
| rd_sel_i | input | 4 | Bin counter select |
| hit_map_o | output | 9 | One bit per legal bin, set on first hit |
| rd_cnt_o | output | CNT_W | Hit count of the selected bin |
| illegal_o | output | 1 | One-cycle illegal-transition pulse |
| illegal_cnt_o | output | ILL_W | Saturating illegal-event count |
| covered_o | output | 4 | Number of covered bins |
| full_o | output | 1 | All bins covered |
| pct_o | output | 7 | Coverage percentage latched at end of test |
| report_vld_o | output | 1 | Percentage has been latched |

## Verification
The end-of-test strobe and a sampled pair can fall on the same edge. This matters most when that pair completes the last uncovered bin. The bench provokes the case by asserting `eot_i` together with the final bin's pair. It expects `pct_o` to show 88 (eight of nine bins) while `full_o` and `covered_o` already show full coverage. A later strobe must then read 100. An exhaustive sweep over all 64 previous/current pairs also makes legal hits, illegal pulses and counter readout coincide with strobes placed at different coverage levels.

// File: rtl/trans_cov_mon.sv
module trans_cov_mon #(
  parameter int CNT_W = 8,
  parameter int ILL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       state_i,
  input  logic             sample_i,
  input  logic             eot_i,
  input  logic [3:0]       rd_sel_i,
  output logic [8:0]       hit_map_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             illegal_o,
  output logic [ILL_W-1:0] illegal_cnt_o,
  output logic [3:0]       covered_o,
  output logic             full_o,
  output logic [6:0]       pct_o,
  output logic             report_vld_o
);
  localparam int NBINS = 9;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ILL_W-1:0] ILL_MAX = {ILL_W{1'b1}};

  function automatic logic [4:0] lookup(input logic [2:0] p, input logic [2:0] c);
    case ({p, c})
      6'o01:   return {1'b1, 4'd0};
      6'o12:   return {1'b1, 4'd1};
      6'o23:   return {1'b1, 4'd2};
      6'o34:   return {1'b1, 4'd3};
      6'o31:   return {1'b1, 4'd4};
      6'o45:   return {1'b1, 4'd5};
      6'o46:   return {1'b1, 4'd6};
      6'o47:   return {1'b1, 4'd7};
      6'o73:   return {1'b1, 4'd8};
      default: return 5'd0;
    endcase
  endfunction

  logic [2:0]       prev_q;
  logic             prev_vld_q;
  logic [4:0]       hit;
  logic             moved, legal_ev, bad_ev;
  logic [CNT_W-1:0] cnt_q [NBINS];
  logic [9:0]       pct_prod;

  assign hit      = lookup(prev_q, state_i);
  assign moved    = sample_i && prev_vld_q && (state_i != prev_q);
  assign legal_ev = moved && hit[4];
  assign bad_ev   = moved && !hit[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (sample_i) begin
      prev_q     <= state_i;
      prev_vld_q <= 1'b1;
    end

  for (genvar k = 0; k < NBINS; k++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt_q[k]     <= '0;
        hit_map_o[k] <= 1'b0;
      end else if (legal_ev && hit[3:0] == 4'(k)) begin
        hit_map_o[k] <= 1'b1;
        if (cnt_q[k] != CNT_MAX) cnt_q[k] <= cnt_q[k] + 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      illegal_o     <= 1'b0;
      illegal_cnt_o <= '0;
    end else begin
      illegal_o <= bad_ev;
      if (bad_ev && illegal_cnt_o != ILL_MAX) illegal_cnt_o <= illegal_cnt_o + 1'b1;
    end

  always_comb begin
    covered_o = '0;
    for (int i = 0; i < NBINS; i++) covered_o = covered_o + {3'd0, hit_map_o[i]};
  end

  assign full_o   = (covered_o == 4'(NBINS));
  assign rd_cnt_o = (rd_sel_i < 4'(NBINS)) ? cnt_q[rd_sel_i] : '0;
  assign pct_prod = {6'd0, covered_o} * 10'd100;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pct_o        <= '0;
      report_vld_o <= 1'b0;
    end else if (eot_i) begin
      pct_o        <= 7'(pct_prod / 10'd9);
      report_vld_o <= 1'b1;
    end

  p_first_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !prev_vld_q) |=> (!illegal_o && $stable(hit_map_o)));

  p_map_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit_map_o & $past(hit_map_o)) == $past(hit_map_o)));

  p_ill_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_cnt_o == ILL_MAX) |=> (illegal_cnt_o == ILL_MAX));

  p_same_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && prev_vld_q && state_i == prev_q) |=> (!illegal_o && $stable(hit_map_o)));

  p_pulse_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ((illegal_cnt_o == $past(illegal_cnt_o) + 1'b1) || (illegal_cnt_o == ILL_MAX)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> (!illegal_o && $stable(hit_map_o) && $stable(illegal_cnt_o) && $stable(prev_q)));
endmodule

// File: tb/test_trans_cov_mon.sv
module test_trans_cov_mon;
  logic clk = 0, rst_n = 0;
  logic [2:0] state_i = 0;
  logic sample_i = 0, eot_i = 0;
  logic [3:0] rd_sel_i = 0;
  logic [8:0] hit_map_o;
  logic [7:0] rd_cnt_o, illegal_cnt_o;
  logic illegal_o, full_o, report_vld_o;
  logic [3:0] covered_o;
  logic [6:0] pct_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [8:0] m_map;
  int m_cnt [9];
  int m_ill, m_pct;
  bit m_ill_p, m_rv, m_pv;
  logic [2:0] m_prev;

  always #2.5 clk = ~clk;

  trans_cov_mon i_trans_cov_mon (.*);

  function automatic int bin_of(input int p, input int c);
    if (p == 0 && c == 1) return 0;
    if (p == 1 && c == 2) return 1;
    if (p == 2 && c == 3) return 2;
    if (p == 3 && c == 4) return 3;
    if (p == 3 && c == 1) return 4;
    if (p == 4 && c == 5) return 5;
    if (p == 4 && c == 6) return 6;
    if (p == 4 && c == 7) return 7;
    if (p == 7 && c == 3) return 8;
    return -1;
  endfunction

  function automatic int popc(input logic [8:0] v);
    int s = 0;
    for (int i = 0; i < 9; i++) s += int'(v[i]);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_map = '0; m_ill = 0; m_pct = 0; m_ill_p = 0; m_rv = 0; m_pv = 0; m_prev = 0;
    for (int i = 0; i < 9; i++) m_cnt[i] = 0;
  endtask

  task automatic check_all(input string req);
    chk(hit_map_o == m_map, {req, " map"}, int'(hit_map_o), int'(m_map));
    chk(illegal_o == m_ill_p, {req, " illegal_o"}, int'(illegal_o), int'(m_ill_p));
    chk(int'(illegal_cnt_o) == m_ill, {req, " illegal cnt"}, int'(illegal_cnt_o), m_ill);
    chk(int'(covered_o) == popc(m_map), "R8 covered", int'(covered_o), popc(m_map));
    chk(full_o == (m_map == 9'h1FF), "R8 full", int'(full_o), int'(m_map == 9'h1FF));
    chk(int'(pct_o) == m_pct, "R9 pct", int'(pct_o), m_pct);
    chk(report_vld_o == m_rv, "R9 valid", int'(report_vld_o), int'(m_rv));
  endtask

  task automatic step(input int st, input bit smp, input bit eot, input string req);
    int b;
    @(negedge clk);
    state_i = 3'(st); sample_i = smp; eot_i = eot;
    if (eot) begin m_pct = popc(m_map) * 100 / 9; m_rv = 1; end
    m_ill_p = 0;
    if (smp) begin
      if (m_pv && int'(m_prev) != st) begin
        b = bin_of(int'(m_prev), st);
        if (b >= 0) begin
          m_map[b] = 1'b1;
          if (m_cnt[b] < 255) m_cnt[b]++;
        end else begin
          m_ill_p = 1;
          if (m_ill < 255) m_ill++;
        end
      end
      m_prev = 3'(st); m_pv = 1;
    end
    @(posedge clk); #1;
    check_all(req);
  endtask

  task automatic check_counters(input string req);
    for (int s = 0; s < 16; s++) begin
      rd_sel_i = 4'(s); #0.5;
      if (s < 9) chk(int'(rd_cnt_o) == m_cnt[s], req, int'(rd_cnt_o), m_cnt[s]);
      else chk(rd_cnt_o == 8'd0, "R10 out of range", int'(rd_cnt_o), 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sample_i = 0; eot_i = 0;
    @(negedge clk); rst_n = 1;
    model_reset(); #0.5;
    check_all("R1 reset");
    check_counters("R1 counters");
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();
    // R2: first sample after reset forms no pair, even from a legal-looking sequence
    step(1, 1, 0, "R2 first sample");
    step(2, 1, 0, "R3 legal 1->2");
    // R7: idle cycles with changing state
    step(5, 0, 0, "R7 idle");
    step(0, 0, 0, "R7 idle");
    step(3, 1, 0, "R3 held prev 2->3");
    // R5: repeated state
    step(3, 1, 0, "R5 same state");
    step(3, 1, 1, "R5 same state with eot");
    // exhaustive pair sweep
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        step(a, 1, 0, "R3/R6 sweep");
        step(b, 1, (a + b) % 11 == 0, "R3/R6/R9 sweep");
      end
    check_counters("R3 counters after sweep");
    step(0, 0, 1, "R9 final pct");
    // R9: strobe coinciding with completion of last bin
    do_reset();
    step(0, 1, 0, "R2");
    step(1, 1, 0, "R3"); step(2, 1, 0, "R3"); step(3, 1, 0, "R3");
    step(4, 1, 0, "R3"); step(7, 1, 0, "R3"); step(3, 1, 0, "R3");
    step(1, 1, 0, "R3"); step(2, 1, 0, "R3"); step(3, 1, 0, "R3");
    step(4, 1, 0, "R3"); step(5, 1, 1, "R9 eot 7 bins");
    step(4, 1, 0, "R6 5->4");
    step(6, 1, 1, "R9 eot same edge as last bin");
    step(6, 0, 1, "R9 eot full");
    check_counters("R3 counters");
    // R4: saturation of a bin counter and the illegal counter
    do_reset();
    step(0, 1, 0, "R2");
    for (int i = 0; i < 300; i++) begin
      step(1, 1, 0, "R4 bin sat");
      step(0, 1, 0, "R4 ill sat");
    end
    check_counters("R4 counters");
    finish_up();
  end
endmodule